// File: doc/BRIEF.md
# Triggered Sample-Averaging Conversion Sequencer

This block sits between a 12-bit successive-approximation converter and the rest of a microcontroller. It picks one start source out of four: a software strobe, either of two timer overflow pulses, or an asynchronous external pin. On a start from the chosen source it asks the converter for 1, 4, 8 or 16 samples in turn, using a one-cycle request and a done handshake. It adds the samples into a 16-bit sum. When the last sample arrives, it places the sum in a result register, sets a completion flag and, if enabled, raises an interrupt.

In burst mode the converter is powered down while the sequencer is idle. A start powers it up and waits a programmable settling time. The sequencer then takes every sample of the set and drops power again as soon as the sum is latched, with no processor involvement. Outside burst mode the converter stays powered and the first request follows the start directly. In both modes one start produces the whole set of samples. A start that arrives while a set is in progress is dropped.

Top module: `adc_seq_top`

## Requirements
- R1: `src_sel` picks the start source (00 software strobe, 01 timer-2 overflow, 10 timer-3 overflow, 11 external pin). Pulses on any source that is not selected have no effect.
- R2: The external pin passes through a two-flop synchronizer and acts on its rising edge. The first conversion request therefore comes two cycles later than it does for a start from another source at the same time.
- R3: `avg_sel` sets the number of samples per start (00 one, 01 four, 10 eight, 11 sixteen). Exactly that many requests are issued, and none follow.
- R4: `result` becomes the unsigned 16-bit sum of the 12-bit samples of the set. It is loaded in the cycle after the last `conv_done` and holds its value at all other times (16 × 0xFFF = 0xFFF0).
- R5: `done_flag` is set when `result` is loaded. `irq` equals `done_flag` AND `irq_en`.
- R6: A `flag_clr` strobe clears `done_flag`. If a strobe lands in the same cycle as a completion, the flag stays set.
- R7: `busy` goes high in the cycle after an accepted start and stays high until `result` is loaded. Starts that arrive while `busy` is high are ignored.
- R8: With burst off, `pwr_on` is held high and `conv_req` is asserted in the cycle right after the start is taken.
- R9: With burst on, `pwr_on` is low while idle and rises with `busy`. The first `conv_req` comes `settle_cyc`+1 cycles after the start is taken, and `pwr_on` falls again when `result` is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_sel | input | 2 | Start source select |
| avg_sel | input | 2 | Samples per start select |
| burst_en | input | 1 | Burst power-cycling mode |
| settle_cyc | input | 8 | Power-up settling cycles in burst mode |
| irq_en | input | 1 | Interrupt enable |
| sw_start | input | 1 | Software start strobe |
| tmr2_ovf | input | 1 | Timer-2 overflow pulse |
| tmr3_ovf | input | 1 | Timer-3 overflow pulse |
| ext_start | input | 1 | Asynchronous external start pin |
| flag_clr | input | 1 | Completion flag clear strobe |
| conv_done | input | 1 | Converter sample-ready strobe |
| conv_data | input | 12 | Converter sample value |
| conv_req | output | 1 | One-cycle sample request to the converter |
| pwr_on | output | 1 | Converter power enable |
| busy | output | 1 | Sequence in progress |
| result | output | 16 | Latched accumulated result |
| done_flag | output | 1 | Completion flag |
| irq | output | 1 | Completion interrupt request |

## Verification
Two events can meet in one cycle. The completion that sets `done_flag` can coincide with a software `flag_clr`, and a fresh start from any source can coincide with the `conv_done` that ends or continues a set. The bench provokes both by driving the clear strobe and pulses on every internal source together with a chosen `conv_done`. It then judges the result at the ports: the flag must read set, no extra request may appear, and `busy` must stay low afterward.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETTLE = 2'd1,
        ST_REQ    = 2'd2,
        ST_WAIT   = 2'd3
    } seq_st_e;

    localparam logic [1:0] SRC_SW   = 2'd0;
    localparam logic [1:0] SRC_TMR2 = 2'd1;
    localparam logic [1:0] SRC_TMR3 = 2'd2;
    localparam logic [1:0] SRC_EXT  = 2'd3;

    // Index of the last sample for a given averaging select.
    function automatic logic [4:0] last_index(input logic [1:0] sel);
        case (sel)
            2'd0:    return 5'd0;
            2'd1:    return 5'd3;
            2'd2:    return 5'd7;
            default: return 5'd15;
        endcase
    endfunction

endpackage

// File: rtl/adc_trig_sel.sv
module adc_trig_sel
    import adc_seq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] src_sel,
    input  logic       sw_start,
    input  logic       tmr2_ovf,
    input  logic       tmr3_ovf,
    input  logic       ext_start,
    output logic       trig
);

    localparam int CHAIN = SYNC_STAGES + 1;

    typedef struct packed {
        logic [CHAIN-1:0] chain;
    } sync_t;

    sync_t r_d, r_q;
    logic  ext_pulse;

    always_comb begin
        r_d       = r_q;
        r_d.chain = {r_q.chain[CHAIN-2:0], ext_start};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign ext_pulse = r_q.chain[CHAIN-2] & ~r_q.chain[CHAIN-1];

    always_comb begin
        case (src_sel)
            SRC_SW:   trig = sw_start;
            SRC_TMR2: trig = tmr2_ovf;
            SRC_TMR3: trig = tmr3_ovf;
            default:  trig = ext_pulse;
        endcase
    end

    assert_ext_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ext_pulse |=> !ext_pulse);

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int SMP_W    = 12,
    parameter int ACC_W    = 16,
    parameter int SETTLE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                trig,
    input  logic [1:0]          avg_sel,
    input  logic                burst_en,
    input  logic [SETTLE_W-1:0] settle_cyc,
    input  logic                flag_clr,
    input  logic                conv_done,
    input  logic [SMP_W-1:0]    conv_data,
    output logic                conv_req,
    output logic                busy,
    output logic [ACC_W-1:0]    result,
    output logic                done_flag
);

    localparam int CNT_W = 5;
    localparam int PAD_W = ACC_W - SMP_W;

    typedef struct packed {
        seq_st_e             st;
        logic [SETTLE_W-1:0] scnt;
        logic [CNT_W-1:0]    cnt;
        logic [ACC_W-1:0]    acc;
        logic [ACC_W-1:0]    res;
        logic                flag;
    } ctrl_t;

    ctrl_t            r_d, r_q;
    logic             fin;
    logic [CNT_W-1:0] last_idx;
    logic [ACC_W-1:0] acc_sum;

    assign last_idx = last_index(avg_sel);
    assign acc_sum  = r_q.acc + {{PAD_W{1'b0}}, conv_data};
    assign fin      = (r_q.st == ST_WAIT) && conv_done && (r_q.cnt == last_idx);

    always_comb begin
        r_d = r_q;
        case (r_q.st)
            ST_IDLE: begin
                if (trig) begin
                    r_d.acc  = '0;
                    r_d.cnt  = '0;
                    r_d.scnt = '0;
                    r_d.st   = burst_en ? ST_SETTLE : ST_REQ;
                end
            end
            ST_SETTLE: begin
                r_d.scnt = r_q.scnt + 1'b1;
                if (r_q.scnt == settle_cyc) r_d.st = ST_REQ;
            end
            ST_REQ: r_d.st = ST_WAIT;
            ST_WAIT: begin
                if (conv_done) begin
                    r_d.acc = acc_sum;
                    r_d.cnt = r_q.cnt + 1'b1;
                    r_d.st  = ST_REQ;
                    if (fin) begin
                        r_d.res = acc_sum;
                        r_d.st  = ST_IDLE;
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
        if (flag_clr) r_d.flag = 1'b0;
        if (fin)      r_d.flag = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign conv_req  = (r_q.st == ST_REQ);
    assign busy      = (r_q.st != ST_IDLE);
    assign result    = r_q.res;
    assign done_flag = r_q.flag;

    assert_busy_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !fin) |=> busy);
    assert_result_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !fin |=> $stable(result));
    assert_flag_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fin |=> done_flag);
    assert_flag_clr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !fin) |=> !done_flag);
    assert_cnt_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (r_q.cnt <= last_idx));
    assert_direct_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && trig && !burst_en) |=> conv_req);

endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top #(
    parameter int SMP_W    = 12,
    parameter int ACC_W    = 16,
    parameter int SETTLE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          src_sel,
    input  logic [1:0]          avg_sel,
    input  logic                burst_en,
    input  logic [SETTLE_W-1:0] settle_cyc,
    input  logic                irq_en,
    input  logic                sw_start,
    input  logic                tmr2_ovf,
    input  logic                tmr3_ovf,
    input  logic                ext_start,
    input  logic                flag_clr,
    input  logic                conv_done,
    input  logic [SMP_W-1:0]    conv_data,
    output logic                conv_req,
    output logic                pwr_on,
    output logic                busy,
    output logic [ACC_W-1:0]    result,
    output logic                done_flag,
    output logic                irq
);

    logic trig;

    adc_trig_sel #(.SYNC_STAGES(2)) u_trig (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_sel  (src_sel),
        .sw_start (sw_start),
        .tmr2_ovf (tmr2_ovf),
        .tmr3_ovf (tmr3_ovf),
        .ext_start(ext_start),
        .trig     (trig)
    );

    adc_seq_ctrl #(
        .SMP_W   (SMP_W),
        .ACC_W   (ACC_W),
        .SETTLE_W(SETTLE_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig      (trig),
        .avg_sel   (avg_sel),
        .burst_en  (burst_en),
        .settle_cyc(settle_cyc),
        .flag_clr  (flag_clr),
        .conv_done (conv_done),
        .conv_data (conv_data),
        .conv_req  (conv_req),
        .busy      (busy),
        .result    (result),
        .done_flag (done_flag)
    );

    assign pwr_on = ~burst_en | busy;
    assign irq    = done_flag & irq_en;

    assert_req_powered_R9: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req |-> pwr_on);
    assert_irq_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en && $rose(done_flag)) |-> irq);

endmodule

// File: tb/adc_seq_top_bench.sv
module adc_seq_top_bench;

    localparam time CLK_P = 8ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  src_sel = '0, avg_sel = '0;
    logic        burst_en = 1'b0, irq_en = 1'b0;
    logic [7:0]  settle_cyc = '0;
    logic        sw_start = 1'b0, tmr2_ovf = 1'b0, tmr3_ovf = 1'b0, ext_start = 1'b0;
    logic        flag_clr = 1'b0, conv_done = 1'b0;
    logic [11:0] conv_data = '0;
    logic        conv_req, pwr_on, busy, done_flag, irq;
    logic [15:0] result;

    int vectors = 0;
    int miscompares = 0;

    always #(CLK_P/2) clk = ~clk;

    adc_seq_top u_adc_seq_top (
        .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .avg_sel(avg_sel),
        .burst_en(burst_en), .settle_cyc(settle_cyc), .irq_en(irq_en),
        .sw_start(sw_start), .tmr2_ovf(tmr2_ovf), .tmr3_ovf(tmr3_ovf),
        .ext_start(ext_start), .flag_clr(flag_clr), .conv_done(conv_done),
        .conv_data(conv_data), .conv_req(conv_req), .pwr_on(pwr_on),
        .busy(busy), .result(result), .done_flag(done_flag), .irq(irq)
    );

    function automatic int avg_n(input logic [1:0] sel);
        case (sel)
            2'd0:    return 1;
            2'd1:    return 4;
            2'd2:    return 8;
            default: return 16;
        endcase
    endfunction

    function automatic int first_req_delay(input logic [1:0] src, input logic burst,
                                           input logic [7:0] settle);
        return (burst ? int'(settle) + 1 : 0) + (src == 2'd3 ? 2 : 0);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic fire(input logic [1:0] src);
        @(negedge clk);
        case (src)
            2'd0:    sw_start  = 1'b1;
            2'd1:    tmr2_ovf  = 1'b1;
            2'd2:    tmr3_ovf  = 1'b1;
            default: ext_start = 1'b1;
        endcase
        @(negedge clk);
        sw_start = 1'b0; tmr2_ovf = 1'b0; tmr3_ovf = 1'b0; ext_start = 1'b0;
    endtask

    task automatic run_seq(input logic [1:0] src, input logic burst, input logic [1:0] avg,
                           input logic [7:0] settle, input logic ien, input logic clr_last,
                           input logic extra, input logic maxd);
        int n;
        int reqs;
        logic [15:0] sum;
        logic [11:0] d;
        @(negedge clk);
        src_sel = src; burst_en = burst; avg_sel = avg; settle_cyc = settle; irq_en = ien;
        @(negedge clk);
        chk("R9 idle power", 32'(pwr_on), 32'(!burst));
        chk("R7 idle busy", 32'(busy), 32'd0);
        fire(src);
        sum = '0;
        for (int i = 0; i < avg_n(avg); i++) begin
            n = 0;
            while (!conv_req && n < 300) begin
                @(negedge clk);
                n++;
            end
            if (i == 0)
                chk(src == 2'd3 ? "R2 first request delay" :
                    (burst ? "R9 first request delay" : "R8 first request delay"),
                    32'(n), 32'(first_req_delay(src, burst, settle)));
            if (!conv_req) begin
                chk("R3 request missing", 32'd0, 32'd1);
                break;
            end
            chk("R7 busy during set", 32'(busy), 32'd1);
            repeat (1 + $urandom % 3) @(negedge clk);
            d = maxd ? 12'hFFF : 12'($urandom);
            sum += 16'(d);
            conv_done = 1'b1; conv_data = d;
            if (clr_last && i == avg_n(avg) - 1) flag_clr = 1'b1;
            if (extra && i == 0) begin
                sw_start = 1'b1; tmr2_ovf = 1'b1; tmr3_ovf = 1'b1;
            end
            @(negedge clk);
            conv_done = 1'b0; flag_clr = 1'b0;
            sw_start = 1'b0; tmr2_ovf = 1'b0; tmr3_ovf = 1'b0;
        end
        chk("R4 result", 32'(result), 32'(sum));
        chk(clr_last ? "R6 set beats clear" : "R5 flag set", 32'(done_flag), 32'd1);
        chk("R5 irq", 32'(irq), 32'(ien));
        chk("R7 busy released", 32'(busy), 32'd0);
        chk("R9 power after set", 32'(pwr_on), 32'(!burst));
        reqs = 0;
        repeat (4) begin
            @(negedge clk);
            if (conv_req || busy) reqs++;
        end
        chk("R3 no extra requests", 32'(reqs), 32'd0);
        chk("R4 result held", 32'(result), 32'(sum));
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        chk("R6 flag cleared", 32'(done_flag), 32'd0);
        chk("R5 irq cleared", 32'(irq), 32'd0);
    endtask

    task automatic unselected_check;
        int hits;
        @(negedge clk);
        src_sel = 2'd1; burst_en = 1'b0;
        @(negedge clk);
        sw_start = 1'b1; tmr3_ovf = 1'b1; ext_start = 1'b1;
        @(negedge clk);
        sw_start = 1'b0; tmr3_ovf = 1'b0; ext_start = 1'b0;
        hits = 0;
        repeat (6) begin
            @(negedge clk);
            if (busy || conv_req) hits++;
        end
        chk("R1 unselected sources ignored", 32'(hits), 32'd0);
    endtask

    initial begin
        #(CLK_P * 150000);
        miscompares++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R7 reset busy", 32'(busy), 32'd0);
        chk("R5 reset flag", 32'(done_flag), 32'd0);
        chk("R4 reset result", 32'(result), 32'd0);
        chk("R8 reset power", 32'(pwr_on), 32'd1);

        run_seq(2'd0, 1'b0, 2'd0, 8'd0, 1'b0, 1'b0, 1'b0, 1'b0);
        run_seq(2'd1, 1'b0, 2'd1, 8'd0, 1'b1, 1'b0, 1'b1, 1'b0);
        run_seq(2'd2, 1'b1, 2'd2, 8'd0, 1'b1, 1'b0, 1'b1, 1'b0);
        run_seq(2'd3, 1'b1, 2'd3, 8'd3, 1'b1, 1'b1, 1'b0, 1'b0);
        run_seq(2'd0, 1'b0, 2'd3, 8'd0, 1'b0, 1'b1, 1'b1, 1'b1);
        run_seq(2'd3, 1'b0, 2'd0, 8'd0, 1'b1, 1'b1, 1'b0, 1'b0);
        unselected_check();

        for (int k = 0; k < 14; k++) begin
            logic [1:0] s;
            s = 2'($urandom);
            run_seq(s, 1'($urandom), 2'($urandom), 8'($urandom % 6),
                    1'($urandom), 1'($urandom), (s != 2'd3) ? 1'($urandom) : 1'b0, 1'b0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule